// File: doc/BRIEF.md
# Background Parity Rebuild Sequencer

This block sits in the home directory controller of a memory node that has failed. It rebuilds the node's lost cache blocks one at a time. For each block it asks every surviving member of the block's parity group for its copy, which means the other data blocks and the parity block. It folds the returned words together with XOR and writes the result to the alternate location. A single rebuild pointer holds the block number being worked on. Every block below the pointer is already rebuilt. Every block at or above it must still be reconstructed on demand.

A lookup port classifies incoming requests against the pointer. A requester whose block is still pending can submit a degraded read. The sequencer serves that read on the same gather-and-XOR path as the background work, returns the rebuilt word to the requester, and writes nothing. When the pointer moves past the programmed last block, the sequencer raises `done` and enters recovery mode. In that mode every request is redirected straight to the new location. Only a reset returns the block to normal mode.

Top module: `parity_rebuild_seq`

## Requirements
- R1: After reset, `mode` is 0 (normal), `done` is 0, and neither `rd_req_valid` nor `wr_valid` is asserted.
- R2: In normal mode a `start` pulse latches `start_blk` and `end_blk` and moves `mode` to 1 (rebuilding) on the next clock edge. A `start` outside normal mode has no effect.
- R3: For each block being rebuilt, the sequencer issues exactly NUM_SRC read requests. Their `rd_req_src` values run 0, 1, ..., NUM_SRC-1, and `rd_req_addr` is the block's byte address (block number shifted left by BLK_LOG2). Reads are issued only while `mode` is 1.
- R4: The rebuilt word is the XOR of all NUM_SRC response words, whatever order they arrive in. It is written with `wr_addr` equal to the block's byte address.
- R5: Background blocks are written in ascending order, from `start_blk` to `end_blk` inclusive, each exactly once. The pointer moves up by one block only after `wr_ack`.
- R6: While `mode` is 1, `cls_kind` reports 1 (redirect) for a block below the pointer. It reports 3 (hold) for the background block currently in flight, and 2 (degraded) for any other block.
- R7: While `mode` is 0, `cls_kind` reports 0 (home access).
- R8: A degraded request (`dg_valid`, `dg_blk`) is accepted between background blocks, ahead of the next background block. Its XOR result appears on `dg_rsp_data` with a one-cycle `dg_rsp_valid`, and no write is issued for it.
- R9: Once the pointer passes `end_blk`, `done` rises and `mode` becomes 2 (recovery), and both hold until reset. If `end_blk` is below `start_blk`, the sequencer reaches recovery with no write.
- R10: In recovery mode `cls_kind` is always 1, and no reads or writes are issued.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin rebuilding (normal mode only) |
| start_blk | input | BIDX_W | First block number of the failed range |
| end_blk | input | BIDX_W | Last block number of the failed range, inclusive |
| mode | output | 2 | 0 normal, 1 rebuilding, 2 recovery |
| done | output | 1 | Rebuild finished |
| rd_req_valid | output | 1 | Read request to a surviving node |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the block being gathered |
| rd_req_src | output | SRC_W | Index of the surviving group member to read |
| rd_rsp_valid | input | 1 | Returned word valid |
| rd_rsp_data | input | DATA_W | Returned word |
| wr_valid | output | 1 | Rebuilt block write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Byte address of the rebuilt block |
| wr_data | output | DATA_W | Rebuilt word |
| wr_ack | input | 1 | Write completed at the alternate location |
| cls_blk | input | BIDX_W | Block number of an incoming request |
| cls_kind | output | 2 | 0 home, 1 redirect, 2 degraded, 3 hold |
| dg_valid | input | 1 | Degraded read request |
| dg_blk | input | BIDX_W | Block number for the degraded read |
| dg_ready | output | 1 | Degraded read accepted this cycle |
| dg_rsp_valid | output | 1 | Degraded result valid |
| dg_rsp_data | output | DATA_W | Degraded result word |

## Verification
The hardest state to reach is a background block sitting in flight, in its gather or awaiting its write acknowledge, at the same moment as a lookup and a degraded request arrive. The bench gets there by watching the write port until the third block appears. It then probes the in-flight block, both of its neighbours and the range start within that one cycle, and posts a degraded read for a block further ahead. The responder answers reads last-in first-out with gaps, and the write and read ready lines follow independent duty patterns, so arrival order and stalls vary from block to block.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL   = 2'd0,
      MODE_REBUILD  = 2'd1,
      MODE_RECOVERY = 2'd2
   } rcs_mode_e;

   typedef enum logic [1:0] {
      CLS_HOME     = 2'd0,
      CLS_REMAP    = 2'd1,
      CLS_DEGRADED = 2'd2,
      CLS_HOLD     = 2'd3
   } rcs_cls_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PICK,
      ST_GATHER,
      ST_WRITE,
      ST_WACK,
      ST_DONE
   } rcs_state_e;
endpackage

// File: rtl/rcs_xor_gather.sv
`timescale 1ns/1ps
module rcs_xor_gather #(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 64,
   parameter int NUM_SRC = 4,
   localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   output logic [SRC_W-1:0]  rd_req_src,
   input  logic              rd_rsp_valid,
   input  logic [DATA_W-1:0] rd_rsp_data
);
   localparam int CNT_W = $clog2(NUM_SRC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_SRC);

   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  iss_q;
   logic [CNT_W-1:0]  rsp_q;
   logic [DATA_W-1:0] acc_q;
   logic              rsp_take;

   assign rd_req_valid = busy_q && (iss_q < LAST);
   assign rd_req_addr  = addr_q;
   assign rd_req_src   = iss_q[SRC_W-1:0];
   assign rsp_take     = busy_q && rd_rsp_valid && (rsp_q < LAST);
   assign done         = busy_q && (rsp_q == LAST);
   assign result       = acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
         iss_q  <= '0;
         rsp_q  <= '0;
         acc_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         addr_q <= base_addr;
         iss_q  <= '0;
         rsp_q  <= '0;
         acc_q  <= '0;
      end else if (busy_q) begin
         if (rd_req_valid && rd_req_ready) iss_q <= iss_q + CNT_W'(1);
         if (rsp_take) begin
            acc_q <= acc_q ^ rd_rsp_data;
            rsp_q <= rsp_q + CNT_W'(1);
         end
         if (done) busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rcs_classify.sv
`timescale 1ns/1ps
module rcs_classify
   import rcs_pkg::*;
#(
   parameter int BIDX_W        = 14,
   parameter bit HOLD_INFLIGHT = 1'b1,
   localparam int PTR_W        = BIDX_W + 1
) (
   input  rcs_mode_e         mode,
   input  logic [PTR_W-1:0]  ptr,
   input  logic              inflight,
   input  logic [BIDX_W-1:0] q_blk,
   output rcs_cls_e          kind
);
   logic [PTR_W-1:0] q_ext;
   logic             hold_en;

   assign q_ext = {1'b0, q_blk};

   if (HOLD_INFLIGHT) begin : g_hold
      assign hold_en = inflight;
   end else begin : g_nohold
      logic unused_inflight;
      assign unused_inflight = inflight;
      assign hold_en = 1'b0;
   end

   always_comb begin
      kind = CLS_HOME;
      case (mode)
         MODE_NORMAL:   kind = CLS_HOME;
         MODE_RECOVERY: kind = CLS_REMAP;
         default: begin
            if (q_ext < ptr)                   kind = CLS_REMAP;
            else if (q_ext == ptr && hold_en) kind = CLS_HOLD;
            else                               kind = CLS_DEGRADED;
         end
      endcase
   end
endmodule

// File: rtl/rcs_ctrl.sv
`timescale 1ns/1ps
module rcs_ctrl
   import rcs_pkg::*;
#(
   parameter int BIDX_W   = 14,
   parameter int BLK_LOG2 = 6,
   parameter int DATA_W   = 64,
   localparam int ADDR_W  = BIDX_W + BLK_LOG2,
   localparam int PTR_W   = BIDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BIDX_W-1:0] start_blk,
   input  logic [BIDX_W-1:0] end_blk,
   output logic              g_start,
   output logic [ADDR_W-1:0] g_addr,
   input  logic              g_done,
   input  logic [DATA_W-1:0] g_result,
   input  logic              dg_valid,
   input  logic [BIDX_W-1:0] dg_blk,
   output logic              dg_ready,
   output logic              dg_rsp_valid,
   output logic [DATA_W-1:0] dg_rsp_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ack,
   output rcs_mode_e         mode,
   output logic              done,
   output logic [PTR_W-1:0]  ptr,
   output logic              inflight
);
   rcs_state_e        st_q, st_d;
   logic [PTR_W-1:0]  ptr_q;
   logic [BIDX_W-1:0] end_q;
   logic              own_dmd_q;
   logic [DATA_W-1:0] wdat_q;
   logic              dgv_q;
   logic [DATA_W-1:0] dgd_q;
   logic              past_end;

   assign past_end = ptr_q > {1'b0, end_q};

   always_comb begin
      st_d     = st_q;
      g_start  = 1'b0;
      g_addr   = {ptr_q[BIDX_W-1:0], BLK_LOG2'(0)};
      dg_ready = 1'b0;
      case (st_q)
         ST_IDLE: if (start) st_d = ST_PICK;
         ST_PICK: begin
            if (dg_valid) begin
               dg_ready = 1'b1;
               g_start  = 1'b1;
               g_addr   = {dg_blk, BLK_LOG2'(0)};
               st_d     = ST_GATHER;
            end else if (past_end) begin
               st_d = ST_DONE;
            end else begin
               g_start = 1'b1;
               st_d    = ST_GATHER;
            end
         end
         ST_GATHER: if (g_done) st_d = own_dmd_q ? ST_PICK : ST_WRITE;
         ST_WRITE:  if (wr_ready) st_d = ST_WACK;
         ST_WACK:   if (wr_ack) st_d = ST_PICK;
         default:   st_d = ST_DONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         ptr_q     <= '0;
         end_q     <= '0;
         own_dmd_q <= 1'b0;
         wdat_q    <= '0;
         dgv_q     <= 1'b0;
         dgd_q     <= '0;
      end else begin
         st_q  <= st_d;
         dgv_q <= 1'b0;
         if (st_q == ST_IDLE && start) begin
            ptr_q <= {1'b0, start_blk};
            end_q <= end_blk;
         end
         if (g_start) own_dmd_q <= dg_ready;
         if (st_q == ST_GATHER && g_done) begin
            if (own_dmd_q) begin
               dgv_q <= 1'b1;
               dgd_q <= g_result;
            end else begin
               wdat_q <= g_result;
            end
         end
         if (st_q == ST_WACK && wr_ack) ptr_q <= ptr_q + PTR_W'(1);
      end
   end

   assign wr_valid     = (st_q == ST_WRITE);
   assign wr_addr      = {ptr_q[BIDX_W-1:0], BLK_LOG2'(0)};
   assign wr_data      = wdat_q;
   assign dg_rsp_valid = dgv_q;
   assign dg_rsp_data  = dgd_q;
   assign done         = (st_q == ST_DONE);
   assign ptr          = ptr_q;
   assign inflight     = (st_q == ST_GATHER && !own_dmd_q) ||
                         (st_q == ST_WRITE) || (st_q == ST_WACK);
   assign mode         = (st_q == ST_IDLE) ? MODE_NORMAL :
                         (st_q == ST_DONE) ? MODE_RECOVERY : MODE_REBUILD;
endmodule

// File: rtl/parity_rebuild_seq.sv
`timescale 1ns/1ps
module parity_rebuild_seq
   import rcs_pkg::*;
#(
   parameter int BIDX_W        = 14,
   parameter int BLK_LOG2      = 6,
   parameter int DATA_W        = 64,
   parameter int NUM_SRC       = 4,
   parameter bit HOLD_INFLIGHT = 1'b1,
   localparam int ADDR_W       = BIDX_W + BLK_LOG2,
   localparam int SRC_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BIDX_W-1:0] start_blk,
   input  logic [BIDX_W-1:0] end_blk,
   output logic [1:0]        mode,
   output logic              done,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   output logic [SRC_W-1:0]  rd_req_src,
   input  logic              rd_rsp_valid,
   input  logic [DATA_W-1:0] rd_rsp_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ack,
   input  logic [BIDX_W-1:0] cls_blk,
   output logic [1:0]        cls_kind,
   input  logic              dg_valid,
   input  logic [BIDX_W-1:0] dg_blk,
   output logic              dg_ready,
   output logic              dg_rsp_valid,
   output logic [DATA_W-1:0] dg_rsp_data
);
   localparam int PTR_W = BIDX_W + 1;

   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be at least 1");
   end
   if (BIDX_W < 1 || BLK_LOG2 < 1) begin : g_bad_addr
      $error("BIDX_W and BLK_LOG2 must be positive");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic              g_start;
   logic [ADDR_W-1:0] g_addr;
   logic              g_done;
   logic [DATA_W-1:0] g_result;
   logic [PTR_W-1:0]  rb_ptr;
   logic              rb_inflight;
   rcs_mode_e         mode_e;
   rcs_cls_e          kind_e;

   rcs_xor_gather #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NUM_SRC(NUM_SRC)
   ) i_gather (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (g_start),
      .base_addr   (g_addr),
      .done        (g_done),
      .result      (g_result),
      .rd_req_valid(rd_req_valid),
      .rd_req_ready(rd_req_ready),
      .rd_req_addr (rd_req_addr),
      .rd_req_src  (rd_req_src),
      .rd_rsp_valid(rd_rsp_valid),
      .rd_rsp_data (rd_rsp_data)
   );

   rcs_ctrl #(
      .BIDX_W  (BIDX_W),
      .BLK_LOG2(BLK_LOG2),
      .DATA_W  (DATA_W)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_blk   (start_blk),
      .end_blk     (end_blk),
      .g_start     (g_start),
      .g_addr      (g_addr),
      .g_done      (g_done),
      .g_result    (g_result),
      .dg_valid    (dg_valid),
      .dg_blk      (dg_blk),
      .dg_ready    (dg_ready),
      .dg_rsp_valid(dg_rsp_valid),
      .dg_rsp_data (dg_rsp_data),
      .wr_valid    (wr_valid),
      .wr_ready    (wr_ready),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .wr_ack      (wr_ack),
      .mode        (mode_e),
      .done        (done),
      .ptr         (rb_ptr),
      .inflight    (rb_inflight)
   );

   rcs_classify #(
      .BIDX_W       (BIDX_W),
      .HOLD_INFLIGHT(HOLD_INFLIGHT)
   ) i_classify (
      .mode    (mode_e),
      .ptr     (rb_ptr),
      .inflight(rb_inflight),
      .q_blk   (cls_blk),
      .kind    (kind_e)
   );

   assign mode     = mode_e;
   assign cls_kind = kind_e;
endmodule

// File: rtl/parity_rebuild_seq_chk.sv
`timescale 1ns/1ps
module parity_rebuild_seq_chk #(
   parameter int PTR_W  = 15,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              done,
   input logic              rd_req_valid,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_ack,
   input logic [1:0]        cls_kind,
   input logic              dg_valid,
   input logic              dg_ready,
   input logic              dg_rsp_valid,
   input logic [PTR_W-1:0]  rb_ptr
);
   AST_RECOV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd2 |=> mode == 2'd2);                                   // R9
   AST_DONE_IN_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> mode == 2'd2);                                           // R9
   AST_RECOV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd2 |-> !rd_req_valid && !wr_valid);                     // R10
   AST_RECOV_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd2 |-> cls_kind == 2'd1);                               // R10
   AST_NORMAL_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd0 |-> cls_kind == 2'd0);                               // R7
   AST_READ_IN_REBUILD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> mode == 2'd1);                                   // R3
   AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R11
   AST_PTR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode) == 2'd1 && mode == 2'd1 && !$stable(rb_ptr)
      |-> rb_ptr == $past(rb_ptr) + PTR_W'(1) && $past(wr_ack));        // R5
   AST_DEMAND_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      dg_ready |-> dg_valid && mode == 2'd1);                           // R8
   AST_DEMAND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      dg_rsp_valid |-> mode == 2'd1 && !wr_valid);                      // R8
endmodule

bind parity_rebuild_seq parity_rebuild_seq_chk #(
   .PTR_W (BIDX_W + 1),
   .ADDR_W(BIDX_W + BLK_LOG2),
   .DATA_W(DATA_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (mode),
   .done        (done),
   .rd_req_valid(rd_req_valid),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .wr_ack      (wr_ack),
   .cls_kind    (cls_kind),
   .dg_valid    (dg_valid),
   .dg_ready    (dg_ready),
   .dg_rsp_valid(dg_rsp_valid),
   .rb_ptr      (rb_ptr)
);

// File: tb/test_parity_rebuild_seq.sv
`timescale 1ns/1ps
module test_parity_rebuild_seq;
   localparam int BIDX_W = 14, BLK_LOG2 = 6, DATA_W = 64, NUM_SRC = 4;
   localparam int ADDR_W = BIDX_W + BLK_LOG2, SRC_W = 2;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [BIDX_W-1:0] start_blk = '0, end_blk = '0, cls_blk = '0, dg_blk = '0;
   logic [1:0] mode, cls_kind;
   logic done, rd_req_valid, rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
   logic [ADDR_W-1:0] rd_req_addr, wr_addr;
   logic [SRC_W-1:0] rd_req_src;
   logic [DATA_W-1:0] rd_rsp_data = '0, wr_data, dg_rsp_data;
   logic wr_valid, wr_ready = 1'b0, wr_ack = 1'b0;
   logic dg_valid = 1'b0, dg_ready, dg_rsp_valid;

   parity_rebuild_seq i_parity_rebuild_seq (.*);

   always #2 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] src_word(input logic [ADDR_W-1:0] a,
                                                  input logic [SRC_W-1:0] s);
      logic [63:0] x;
      x = {44'h0, a} * 64'h9E3779B97F4A7C15;
      x = x ^ (({62'h0, s} + 64'd1) * 64'hC2B2AE3D27D4EB4F);
      return x ^ {a, 42'h0, s};
   endfunction

   function automatic logic [DATA_W-1:0] blk_word(input int b);
      logic [DATA_W-1:0] r = '0;
      for (int s = 0; s < NUM_SRC; s++)
         r ^= src_word({BIDX_W'(b), BLK_LOG2'(0)}, SRC_W'(s));
      return r;
   endfunction

   typedef struct packed {
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
   } wexp_t;
   wexp_t sb[$];
   typedef struct packed {
      logic [ADDR_W-1:0] a;
      logic [SRC_W-1:0]  s;
   } rreq_t;
   rreq_t pend[$];

   task automatic push_range(input int first, input int last);
      for (int b = first; b <= last; b++)
         sb.push_back({ADDR_W'({BIDX_W'(b), BLK_LOG2'(0)}), blk_word(b)});
   endtask

   int cyc = 0, writes = 0, reads = 0, dg_seen = 0, ack_wait = 0;
   logic [SRC_W-1:0] exp_src = '0;
   logic [DATA_W-1:0] dg_exp = '0;
   bit stalled = 1'b0;
   logic [ADDR_W-1:0] st_a;
   logic [DATA_W-1:0] st_d;

   // responder and scoreboard monitor
   always @(negedge clk) begin
      cyc++;
      rd_rsp_valid = 1'b0;
      if (pend.size() > 0 && (pend.size() >= 2 || !rd_req_valid)) begin
         rreq_t r;
         r = pend.pop_back();
         rd_rsp_valid = 1'b1;
         rd_rsp_data  = src_word(r.a, r.s);
      end
      rd_req_ready = (cyc % 4) != 1;
      if (rd_req_valid && rd_req_ready) begin
         reads++;
         check(rd_req_src == exp_src, "R3", "read source order", 64'(rd_req_src), 64'(exp_src));
         check(rd_req_addr[BLK_LOG2-1:0] == '0, "R3", "read address aligned",
               64'(rd_req_addr), 64'(rd_req_addr & ~ADDR_W'(63)));
         exp_src = exp_src + SRC_W'(1);
         pend.push_back({rd_req_addr, rd_req_src});
      end
      wr_ack = 1'b0;
      if (ack_wait > 0) begin
         ack_wait--;
         if (ack_wait == 0) wr_ack = 1'b1;
      end
      if (stalled) begin
         check(wr_valid && wr_addr == st_a && wr_data == st_d, "R11",
               "write held while stalled", wr_data, st_d);
      end
      wr_ready = (cyc % 3) != 0;
      stalled = wr_valid && !wr_ready;
      st_a = wr_addr;
      st_d = wr_data;
      if (wr_valid && wr_ready) begin
         writes++;
         if (sb.size() == 0) begin
            check(1'b0, "R5", "unexpected write", 64'(wr_addr), 64'h0);
         end else begin
            wexp_t e;
            e = sb.pop_front();
            check(wr_addr == e.a, "R5", "write address order", 64'(wr_addr), 64'(e.a));
            check(wr_data == e.d, "R4", "rebuilt word", wr_data, e.d);
         end
         ack_wait = 2;
      end
      if (dg_rsp_valid) begin
         dg_seen++;
         check(dg_rsp_data == dg_exp, "R8", "degraded result", dg_rsp_data, dg_exp);
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic classify(input int b, input logic [1:0] exp, input string req);
      cls_blk = BIDX_W'(b);
      #0.3;
      check(cls_kind == exp, req, "classification", 64'(cls_kind), 64'(exp));
   endtask

   task automatic kick(input int first, input int last);
      start_blk = BIDX_W'(first);
      end_blk   = BIDX_W'(last);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic run_all();
      // R1 reset state
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(mode == 2'd0, "R1", "mode after reset", 64'(mode), 64'd0);
      check(!done && !rd_req_valid && !wr_valid, "R1", "idle outputs after reset",
            64'({done, rd_req_valid, wr_valid}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      classify(5, 2'd0, "R7");

      // main rebuild of blocks 4..9
      push_range(4, 9);
      kick(4, 9);
      check(mode == 2'd1, "R2", "mode after start", 64'(mode), 64'd1);
      while (!(wr_valid && wr_addr == ADDR_W'({BIDX_W'(6), BLK_LOG2'(0)}))) @(negedge clk);
      #0.1;
      classify(6, 2'd3, "R6");
      classify(5, 2'd1, "R6");
      classify(4, 2'd1, "R6");
      classify(7, 2'd2, "R6");
      // degraded request for a pending block
      dg_blk = BIDX_W'(8);
      dg_exp = blk_word(8);
      dg_valid = 1'b1;
      #0.2;
      while (!dg_ready) begin
         @(negedge clk);
         #0.2;
      end
      @(negedge clk);
      dg_valid = 1'b0;
      wait_done();
      check(mode == 2'd2, "R9", "mode after last block", 64'(mode), 64'd2);
      check(sb.size() == 0 && writes == 6, "R5", "all blocks written once", 64'(writes), 64'd6);
      check(dg_seen == 1, "R8", "one degraded result", 64'(dg_seen), 64'd1);
      check(reads == 7 * NUM_SRC, "R3", "reads per gather", 64'(reads), 64'(7 * NUM_SRC));
      classify(20, 2'd1, "R10");
      classify(4, 2'd1, "R10");
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(!rd_req_valid && !wr_valid, "R10", "no traffic in recovery",
               64'({rd_req_valid, wr_valid}), 64'd0);
      end
      kick(0, 3);
      @(negedge clk);
      check(mode == 2'd2 && done, "R2", "start ignored in recovery", 64'(mode), 64'd2);
      check(writes == 6, "R2", "no write after ignored start", 64'(writes), 64'd6);

      // single block range
      do_reset();
      push_range(2, 2);
      kick(2, 2);
      wait_done();
      check(writes == 7 && sb.size() == 0, "R5", "single block range", 64'(writes), 64'd7);

      // empty range
      do_reset();
      kick(5, 3);
      wait_done();
      repeat (2) @(negedge clk);
      check(writes == 7, "R9", "empty range writes nothing", 64'(writes), 64'd7);
      check(mode == 2'd2, "R9", "empty range reaches recovery", 64'(mode), 64'd2);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            check(1'b0, "WATCHDOG", "run did not finish", 64'(cyc), 64'd0);
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule